// File: doc/BRIEF.md
# Low-Frequency Clock Quality Monitor

This block judges the health of a slow (nominally 32 kHz) clock by timing it against a fast reference clock that runs the whole block. The slow input is brought into the reference domain through a multi-flop synchroniser. Each rising edge closes one period. For each period the block records the period length and the high time in reference cycles, and it compares the period against a programmable window. It also works out how far the high time lies from half the period and counts consecutive good periods, so that it can declare the clock valid and later flag it as unwell if it degrades.

Software reaches the block through a small word-indexed register port. The port holds a control word, limit registers, read-only measurement results, a write-1-to-clear event register and an event mask. A single registered interrupt output is raised while any unmasked event bit is set. The oscillator and the choice of clock source lie outside this block.

Register indices (reg_addr): 0 control, 1 events, 2 event mask, 3 period low limit, 4 period high limit, 5 duty-deviation limit, 6 valid threshold, 7 period result, 8 high-time result, 9 duty-deviation result, 10 good-period count. Event bits: 0 period done, 1 period in window, 2 duty in limit, 3 period out of window, 4 stalled, 5 valid, 6 unwell.

Top module: `lfclk_monitor`

## Requirements
- R1: With control bit 0 set, the first synchronised rising edge of lf_clk_in after enabling or clearing only arms the block. Each later rising edge loads the period result (index 7) with the reference cycles since the previous rising edge and the high-time result (index 8) with the reference cycles the input was high in that interval.
- R2: Event bit 0 sets after every completed period while control bit 0 is 1. With control bit 0 at 0, no event bit sets.
- R3: For each completed period, event bit 1 sets if low limit <= period <= high limit, and event bit 3 sets otherwise. The two never set for the same period.
- R4: While control bit 1 is set, each completed period loads index 9 with |high - floor(period/2)|. Event bit 2 sets when that value is <= the duty-deviation limit (index 5). With control bit 1 at 0, event bit 2 never sets.
- R5: While control bit 2 is set, each in-window period increments the good-period count (index 10), saturating at 255. Each out-of-window or stalled period zeroes it. Event bit 5 sets on the period where the count first reaches the valid threshold. With control bit 2 at 0, the count stays 0.
- R6: An out-of-window period or a stall that occurs after validity was reached sets event bit 6 and drops the reached state.
- R7: Once armed, if the period counter reaches 0xFFFF with no rising edge, event bit 4 sets, the period result reads 0xFFFF, and the block disarms.
- R8: Writing control with bit 24 set zeroes all results and counters and disarms the block. Bit 24 reads back as 0.
- R9: Writing 1 to a bit of index 1 clears that event bit. An event that sets in the same cycle as a clear of its bit stays set.
- R10: irq is 1 one cycle after any bit is set in both the event register and the event mask (index 2, same bit layout), and 0 otherwise.
- R11: After reset, events, mask, control, results and the low limit read 0, the high limit reads 0xFFFF and irq is 0. reg_rdata returns the addressed register one cycle after reg_addr is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock for all logic |
| rst | input | 1 | Synchronous active-high reset |
| lf_clk_in | input | 1 | Slow clock under test, asynchronous |
| reg_addr | input | 4 | Register word index |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| irq | output | 1 | Registered interrupt request |

## Verification
The event register can be set by a completed period and cleared by a software write in the same reference cycle. The bench drives the slow clock in lock-step with the reference, so the cycle in which the period-done bit sets is known exactly. It then sweeps a single write-1-to-clear across seven cycle offsets around that rising edge. A clear that lands before or on the setting cycle must leave the bit at 1, and a clear after it must leave it at 0. Reading the register back afterwards shows which of the two events won.

// File: rtl/lfm_pkg.sv
package lfm_pkg;
  localparam int REG_AW = 4;
  localparam int NEVT   = 7;

  localparam logic [REG_AW-1:0] IX_CTRL  = 4'd0;
  localparam logic [REG_AW-1:0] IX_EVT   = 4'd1;
  localparam logic [REG_AW-1:0] IX_MASK  = 4'd2;
  localparam logic [REG_AW-1:0] IX_PLO   = 4'd3;
  localparam logic [REG_AW-1:0] IX_PHI   = 4'd4;
  localparam logic [REG_AW-1:0] IX_DVLIM = 4'd5;
  localparam logic [REG_AW-1:0] IX_VTHR  = 4'd6;
  localparam logic [REG_AW-1:0] IX_PER   = 4'd7;
  localparam logic [REG_AW-1:0] IX_HIGH  = 4'd8;
  localparam logic [REG_AW-1:0] IX_DEV   = 4'd9;
  localparam logic [REG_AW-1:0] IX_GOOD  = 4'd10;

  localparam int EV_DONE   = 0;
  localparam int EV_INWIN  = 1;
  localparam int EV_DUTYOK = 2;
  localparam int EV_OUTWIN = 3;
  localparam int EV_STALL  = 4;
  localparam int EV_VALID  = 5;
  localparam int EV_UNWELL = 6;

  localparam int CB_PER  = 0;
  localparam int CB_DUTY = 1;
  localparam int CB_GOOD = 2;
  localparam int CB_CLR  = 24;
endpackage

// File: rtl/lfm_sync_edge.sv
module lfm_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic level,
  output logic rise
);
  logic [STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-1:0], async_in};
  end

  assign level = chain[STAGES-1];
  assign rise  = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/lfm_measure.sv
module lfm_measure
  import lfm_pkg::*;
#(
  parameter int CW = 16,
  parameter int VW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            level,
  input  logic            rise,
  input  logic            per_en,
  input  logic            duty_en,
  input  logic            good_en,
  input  logic            clr,
  input  logic [CW-1:0]   lim_lo,
  input  logic [CW-1:0]   lim_hi,
  input  logic [CW-1:0]   dev_lim,
  input  logic [VW-1:0]   good_thr,
  output logic [CW-1:0]   period_q,
  output logic [CW-1:0]   high_q,
  output logic [CW-1:0]   dev_q,
  output logic [VW-1:0]   good_q,
  output logic [NEVT-1:0] evt_q
);
  localparam logic [CW-1:0] CSAT = {CW{1'b1}};
  localparam logic [VW-1:0] VSAT = {VW{1'b1}};

  logic          armed, reached;
  logic [CW-1:0] run_cnt, high_run, half, dev;
  logic [VW-1:0] good_next;
  logic          done, in_win, stall_now, bad;

  always_comb begin
    done      = per_en & armed & rise;
    stall_now = per_en & armed & ~rise & (run_cnt == CSAT);
    in_win    = (run_cnt >= lim_lo) && (run_cnt <= lim_hi);
    half      = run_cnt >> 1;
    dev       = (high_run >= half) ? (high_run - half) : (half - high_run);
    good_next = (good_q == VSAT) ? good_q : good_q + 1'b1;
    bad       = (done & ~in_win) | stall_now;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      armed    <= 1'b0;
      reached  <= 1'b0;
      run_cnt  <= '0;
      high_run <= '0;
      period_q <= '0;
      high_q   <= '0;
      dev_q    <= '0;
      good_q   <= '0;
      evt_q    <= '0;
    end else begin
      evt_q <= '0;

      if (!per_en) begin
        armed    <= 1'b0;
        run_cnt  <= '0;
        high_run <= '0;
      end else if (rise) begin
        armed    <= 1'b1;
        run_cnt  <= 1;
        high_run <= 1;
      end else begin
        if (run_cnt != CSAT) run_cnt <= run_cnt + 1'b1;
        if (level && high_run != CSAT) high_run <= high_run + 1'b1;
        if (stall_now) armed <= 1'b0;
      end

      if (done) begin
        period_q         <= run_cnt;
        high_q           <= high_run;
        evt_q[EV_DONE]   <= 1'b1;
        evt_q[EV_INWIN]  <= in_win;
        evt_q[EV_OUTWIN] <= ~in_win;
        if (duty_en) begin
          dev_q            <= dev;
          evt_q[EV_DUTYOK] <= (dev <= dev_lim);
        end
      end

      if (stall_now) begin
        period_q        <= CSAT;
        evt_q[EV_STALL] <= 1'b1;
      end

      if (!good_en) begin
        good_q  <= '0;
        reached <= 1'b0;
      end else if (bad) begin
        good_q <= '0;
        if (reached) begin
          evt_q[EV_UNWELL] <= 1'b1;
          reached          <= 1'b0;
        end
      end else if (done && in_win) begin
        good_q <= good_next;
        if (!reached && good_next >= good_thr) begin
          reached         <= 1'b1;
          evt_q[EV_VALID] <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/lfm_regs.sv
module lfm_regs
  import lfm_pkg::*;
#(
  parameter int CW = 16,
  parameter int VW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [REG_AW-1:0] addr,
  input  logic              wr,
  input  logic [31:0]       wdata,
  input  logic [NEVT-1:0]   evt,
  input  logic [CW-1:0]     period,
  input  logic [CW-1:0]     high,
  input  logic [CW-1:0]     dev,
  input  logic [VW-1:0]     good,
  output logic [31:0]       rdata,
  output logic              irq,
  output logic              per_en,
  output logic              duty_en,
  output logic              good_en,
  output logic              clr,
  output logic [CW-1:0]     lim_lo,
  output logic [CW-1:0]     lim_hi,
  output logic [CW-1:0]     dev_lim,
  output logic [VW-1:0]     good_thr,
  output logic [NEVT-1:0]   evt_st,
  output logic [NEVT-1:0]   evt_mask
);
  logic [NEVT-1:0] w1c;
  logic [31:0]     rd_mux;
  logic            unused_wbits;

  assign unused_wbits = ^{wdata[31:25], wdata[23:CW]};

  always_comb begin
    w1c = (wr && addr == IX_EVT) ? wdata[NEVT-1:0] : '0;
    case (addr)
      IX_CTRL:  rd_mux = {29'd0, good_en, duty_en, per_en};
      IX_EVT:   rd_mux = {{(32-NEVT){1'b0}}, evt_st};
      IX_MASK:  rd_mux = {{(32-NEVT){1'b0}}, evt_mask};
      IX_PLO:   rd_mux = {{(32-CW){1'b0}}, lim_lo};
      IX_PHI:   rd_mux = {{(32-CW){1'b0}}, lim_hi};
      IX_DVLIM: rd_mux = {{(32-CW){1'b0}}, dev_lim};
      IX_VTHR:  rd_mux = {{(32-VW){1'b0}}, good_thr};
      IX_PER:   rd_mux = {{(32-CW){1'b0}}, period};
      IX_HIGH:  rd_mux = {{(32-CW){1'b0}}, high};
      IX_DEV:   rd_mux = {{(32-CW){1'b0}}, dev};
      IX_GOOD:  rd_mux = {{(32-VW){1'b0}}, good};
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      per_en   <= 1'b0;
      duty_en  <= 1'b0;
      good_en  <= 1'b0;
      clr      <= 1'b0;
      lim_lo   <= '0;
      lim_hi   <= {CW{1'b1}};
      dev_lim  <= '0;
      good_thr <= '0;
      evt_st   <= '0;
      evt_mask <= '0;
      irq      <= 1'b0;
      rdata    <= '0;
    end else begin
      clr    <= wr && addr == IX_CTRL && wdata[CB_CLR];
      evt_st <= (evt_st & ~w1c) | evt;
      irq    <= |(evt_st & evt_mask);
      rdata  <= rd_mux;
      if (wr) begin
        case (addr)
          IX_CTRL: begin
            per_en  <= wdata[CB_PER];
            duty_en <= wdata[CB_DUTY];
            good_en <= wdata[CB_GOOD];
          end
          IX_MASK:  evt_mask <= wdata[NEVT-1:0];
          IX_PLO:   lim_lo   <= wdata[CW-1:0];
          IX_PHI:   lim_hi   <= wdata[CW-1:0];
          IX_DVLIM: dev_lim  <= wdata[CW-1:0];
          IX_VTHR:  good_thr <= wdata[VW-1:0];
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/lfclk_monitor.sv
module lfclk_monitor
  import lfm_pkg::*;
#(
  parameter int CW     = 16,
  parameter int VW     = 8,
  parameter int STAGES = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        lf_clk_in,
  input  logic [3:0]  reg_addr,
  input  logic        reg_wr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        irq
);
  logic            lf_level, lf_rise;
  logic            per_en, duty_en, good_en, clr;
  logic [CW-1:0]   lim_lo, lim_hi, dev_lim;
  logic [VW-1:0]   good_thr;
  logic [CW-1:0]   period_q, high_q, dev_q;
  logic [VW-1:0]   good_q;
  logic [NEVT-1:0] evt, evt_st, evt_mask;

  lfm_sync_edge #(.STAGES(STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_in(lf_clk_in),
    .level(lf_level), .rise(lf_rise)
  );

  lfm_measure #(.CW(CW), .VW(VW)) u_meas (
    .clk(clk), .rst(rst), .level(lf_level), .rise(lf_rise),
    .per_en(per_en), .duty_en(duty_en), .good_en(good_en), .clr(clr),
    .lim_lo(lim_lo), .lim_hi(lim_hi), .dev_lim(dev_lim), .good_thr(good_thr),
    .period_q(period_q), .high_q(high_q), .dev_q(dev_q), .good_q(good_q),
    .evt_q(evt)
  );

  lfm_regs #(.CW(CW), .VW(VW)) u_regs (
    .clk(clk), .rst(rst), .addr(reg_addr), .wr(reg_wr), .wdata(reg_wdata),
    .evt(evt), .period(period_q), .high(high_q), .dev(dev_q), .good(good_q),
    .rdata(reg_rdata), .irq(irq),
    .per_en(per_en), .duty_en(duty_en), .good_en(good_en), .clr(clr),
    .lim_lo(lim_lo), .lim_hi(lim_hi), .dev_lim(dev_lim), .good_thr(good_thr),
    .evt_st(evt_st), .evt_mask(evt_mask)
  );
endmodule

// File: rtl/lfm_checker.sv
module lfm_checker
  import lfm_pkg::*;
#(
  parameter int CW = 16,
  parameter int VW = 8
) (
  input logic            clk,
  input logic            rst,
  input logic [NEVT-1:0] evt,
  input logic [NEVT-1:0] evt_st,
  input logic [NEVT-1:0] evt_mask,
  input logic            irq,
  input logic [VW-1:0]   good_q,
  input logic [CW-1:0]   period_q,
  input logic [CW-1:0]   lim_lo,
  input logic [CW-1:0]   lim_hi
);
  p_result_has_done_r2: assert property (@(posedge clk) disable iff (rst)
    (evt[EV_INWIN] || evt[EV_OUTWIN]) |-> evt[EV_DONE]);

  p_pass_excl_fail_r3: assert property (@(posedge clk) disable iff (rst)
    !(evt[EV_INWIN] && evt[EV_OUTWIN]));

  p_pass_in_limits_r3: assert property (@(posedge clk) disable iff (rst)
    evt[EV_INWIN] |-> (period_q >= $past(lim_lo) && period_q <= $past(lim_hi)));

  p_fail_zeroes_count_r5: assert property (@(posedge clk) disable iff (rst)
    (evt[EV_OUTWIN] || evt[EV_STALL]) |-> (good_q == '0));

  p_stall_saturates_r7: assert property (@(posedge clk) disable iff (rst)
    evt[EV_STALL] |-> (period_q == {CW{1'b1}}));

  p_set_wins_r9: assert property (@(posedge clk) disable iff (rst)
    evt[EV_DONE] |=> evt_st[EV_DONE]);

  p_irq_masked_r10: assert property (@(posedge clk) disable iff (rst)
    ($past(evt_mask) == '0) |-> !irq);
endmodule

bind lfclk_monitor lfm_checker #(.CW(CW), .VW(VW)) u_chk (
  .clk(clk), .rst(rst), .evt(evt), .evt_st(evt_st), .evt_mask(evt_mask),
  .irq(irq), .good_q(good_q), .period_q(period_q),
  .lim_lo(lim_lo), .lim_hi(lim_hi)
);

// File: tb/lfclk_monitor_bench.sv
module lfclk_monitor_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lf = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  localparam logic [3:0] A_CTRL = 0, A_EVT = 1, A_MASK = 2, A_PLO = 3, A_PHI = 4,
                         A_DVL = 5, A_VTH = 6, A_PER = 7, A_HIGH = 8, A_DEV = 9, A_GOOD = 10;
  localparam logic [31:0] CLRB = 32'h0100_0000;

  lfclk_monitor u_lfclk_monitor (
    .clk(clk), .rst(rst), .lf_clk_in(lf), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 190000) begin
      failures = failures + 1;
      $display("FAIL watchdog actual=%0d expected<=190000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      failures = failures + 1;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wreg(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rreg(input logic [3:0] a, output logic [31:0] v);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    v = reg_rdata;
  endtask

  task automatic lf_run(input int hi, input int lo, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); lf = 1'b1;
      repeat (hi - 1) @(negedge clk);
      @(negedge clk); lf = 1'b0;
      repeat (lo - 1) @(negedge clk);
    end
  endtask

  task automatic restart(input logic [31:0] ctrl);
    wreg(A_CTRL, ctrl | CLRB);
    wreg(A_EVT, 32'h7F);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rreg(A_EVT, v);  check("R11 events after reset", v, 0);
    rreg(A_PHI, v);  check("R11 high limit after reset", v, 32'hFFFF);
    rreg(A_CTRL, v); check("R11 control after reset", v, 0);
    check("R11 irq after reset", {31'd0, irq}, 0);
  endtask

  task automatic t_disabled;
    logic [31:0] v;
    lf_run(20, 30, 3);
    repeat (8) @(negedge clk);
    rreg(A_EVT, v); check("R2 no events while disabled", v, 0);
  endtask

  task automatic t_measure;
    logic [31:0] v;
    wreg(A_PLO, 40); wreg(A_PHI, 60); wreg(A_DVL, 5);
    restart(32'h3);
    lf_run(20, 30, 3);
    repeat (6) @(negedge clk);
    rreg(A_PER, v);  check("R1 period result", v, 50);
    rreg(A_HIGH, v); check("R1 high result", v, 20);
    rreg(A_DEV, v);  check("R4 duty deviation", v, 5);
    rreg(A_EVT, v);  check("R2 R3 R4 done+inwin+duty ok at limit", v, 32'h07);
  endtask

  task automatic t_outwin;
    logic [31:0] v;
    wreg(A_DVL, 4);
    restart(32'h3);
    lf_run(10, 60, 3);
    repeat (6) @(negedge clk);
    rreg(A_PER, v); check("R1 long period result", v, 70);
    rreg(A_DEV, v); check("R4 deviation of skewed period", v, 25);
    rreg(A_EVT, v); check("R3 R4 out of window, no duty ok", v, 32'h09);
  endtask

  task automatic t_valid;
    logic [31:0] v;
    wreg(A_VTH, 3);
    restart(32'h5);
    lf_run(20, 30, 4);
    repeat (6) @(negedge clk);
    rreg(A_GOOD, v); check("R5 good count after three", v, 3);
    rreg(A_EVT, v);  check("R5 valid set, duty off", v, 32'h23);
    wreg(A_EVT, 32'h7F);
    repeat (100) @(negedge clk);
    lf_run(20, 30, 1);
    repeat (6) @(negedge clk);
    rreg(A_GOOD, v); check("R5 count zeroed by failure", v, 0);
    rreg(A_EVT, v);  check("R6 unwell on failure after valid", v & 32'h68, 32'h48);
  endtask

  task automatic t_irq;
    logic [31:0] v;
    wreg(A_MASK, 0);
    repeat (3) @(negedge clk);
    check("R10 irq low when masked", {31'd0, irq}, 0);
    wreg(A_MASK, 32'h08);
    repeat (2) @(negedge clk);
    check("R10 irq high when unmasked", {31'd0, irq}, 1);
    wreg(A_EVT, 32'h08);
    repeat (3) @(negedge clk);
    check("R10 irq low after clear", {31'd0, irq}, 0);
    rreg(A_EVT, v); check("R9 only written bit cleared", v & 32'h48, 32'h40);
    wreg(A_MASK, 0);
  endtask

  task automatic t_clear;
    logic [31:0] v;
    wreg(A_CTRL, 32'h5 | CLRB);
    rreg(A_PER, v);  check("R8 period cleared", v, 0);
    rreg(A_HIGH, v); check("R8 high cleared", v, 0);
    rreg(A_CTRL, v); check("R8 clear bit reads 0", v, 5);
  endtask

  task automatic t_stall;
    logic [31:0] v;
    wreg(A_VTH, 1);
    restart(32'h5);
    lf_run(20, 30, 2);
    wreg(A_EVT, 32'h7F);
    repeat (66000) @(negedge clk);
    rreg(A_PER, v);  check("R7 period saturates on stall", v, 32'hFFFF);
    rreg(A_EVT, v);  check("R7 R6 stall and unwell", v, 32'h50);
    rreg(A_GOOD, v); check("R5 count zeroed by stall", v, 0);
  endtask

  task automatic t_collide;
    logic [31:0] v;
    restart(32'h1);
    lf_run(20, 30, 1);
    for (int d = 0; d < 7; d++) begin
      wreg(A_EVT, 32'h7F);
      @(negedge clk); lf = 1'b1;
      repeat (d) @(negedge clk);
      reg_addr = A_EVT; reg_wdata = 32'h01; reg_wr = 1'b1;
      @(negedge clk); reg_wr = 1'b0;
      repeat (20 - d - 1) @(negedge clk);
      lf = 1'b0;
      repeat (30) @(negedge clk);
      rreg(A_EVT, v);
      check($sformatf("R9 set vs clear offset %0d", d), v & 32'h1, (d <= 3) ? 32'h1 : 32'h0);
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    t_reset;
    t_disabled;
    t_measure;
    t_outwin;
    t_valid;
    t_irq;
    t_clear;
    t_stall;
    t_collide;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule